// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequence Checker

This block sits beside a two-bank low-power SDRAM interface and observes its control pins at every rising clock edge. It reduces the pin levels of clock enable (previous and current sample), chip select, the three strobes, bank select and the auto-precharge address bit to one named command. That command drives a model of each bank's state and of the device's power state. The block does not drive the memory. It only reports what it sees.

A command that breaks a sequencing rule raises a violation flag and a three-bit code. The rules cover a mode register write or refresh while a bank is open, a command issued too soon after a mode register write, a command before reinitialisation after deep power down, a column access or precharge to an idle bank, an access to a bank that is still finishing an auto-precharge burst, and activation of a bank that is already open. The first code is held until a clear pulse. The burst length that times auto-precharge bursts is taken from the last normal mode register write.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high in both samples, the command output uses the codes no-op 0, mode register 1, extended mode register 2, auto refresh 3, activate 5, read 6, read with auto precharge 7, write 8, write with auto precharge 9, burst stop 10, single-bank precharge 11 and all-bank precharge 12. Chip select low selects a command by {ras_n,cas_n,we_n}: 000 is a mode register write (bank select 0 gives normal, nonzero gives extended), 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge. Address bit a10 high selects auto precharge or all banks. Chip select high, or pattern 111, is a no-op.
- R2: When clock enable falls (previous 1, current 0), pattern 001 gives self refresh entry (4), pattern 110 gives deep power down entry (14), and a no-op or deselect gives power down entry (13). When the previous sample is 0, the command is exit (15) if the current sample is 1 and no-op otherwise.
- R3: Each bank reports 0 idle, 1 active or 2 bursting, in two bits per bank with bank 0 lowest. Activate moves an idle bank to active. Precharge of that bank, or all-bank precharge, returns an active bank to idle. Activating a bank that is not idle raises code 6.
- R4: A read, write or single-bank precharge addressed to an idle bank raises code 4.
- R5: A read or write with auto precharge to an active bank occupies it for the burst length BL. The bank reports bursting on the BL-1 edges that follow and is idle from edge BL onward. With BL 1 it is idle at once. A read, write or precharge to a bursting bank raises code 5. The other bank stays usable meanwhile.
- R6: A mode register write, extended mode register write, auto refresh or self refresh entry while any bank is not idle raises code 1.
- R7: Any command other than no-op, power down entry or exit on either of the two edges after a mode or extended mode register write raises code 2.
- R8: The device state is 0 normal, 1 power down, 2 self refresh, 3 deep power down or 4 awaiting reinitialisation. Entry commands from normal go to 1, 2 or 3. Exit returns 1 and 2 to normal and moves 3 to 4.
- R9: In state 4, any command other than no-op, power down entry, exit or a mode register write raises code 3. A normal mode register write returns the device to state 0.
- R10: The first nonzero code is held, and later violations do not replace it. A clear pulse sets the code to 0 on the next edge, and the flag is high exactly when the code is nonzero.
- R11: A normal mode register write sets BL from its address bits [2:0]: 0, 1, 2 and 3 give 1, 2, 4 and 8, and other values leave BL unchanged. After reset BL is 1.
- R12: While reset is low, the code, the bank states and the device state are all 0, and the command output still decodes the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| viol_clr | input | 1 | Clears the held violation code |
| cke_prev | input | 1 | Clock enable sampled on the previous edge |
| cke | input | 1 | Clock enable on this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| a10 | input | 1 | Auto precharge / all-bank select |
| addr_lo | input | 3 | Low address bits carrying the burst length code |
| cmd_o | output | 4 | Decoded command code |
| bank_state_o | output | 4 | Two-bit state per bank |
| dev_state_o | output | 3 | Device power state |
| viol_o | output | 1 | Violation held |
| viol_code_o | output | 3 | First violation code |

## Verification
The hardest case to reach is the end of an auto-precharge burst, measured against a burst length other than the reset value. The bench first writes the mode register with burst length 4 and waits out the two-edge quiet window. It then opens both banks, issues a read with auto precharge to bank 0 and reads bank 1 on the next edge. Bank 0 is sampled on each following edge until it drops to idle, and an access to it afterwards shows the auto precharge really closed it. Reaching the reinitialisation state also needs a full chain of deep power down entry, a held low clock enable and an exit.

// File: rtl/sdcmd_pkg.sv
// Shared command, bank-state, device-state and violation encodings.
package sdcmd_pkg;
    typedef enum logic [3:0] {
        C_NOP = 4'd0, C_MRS = 4'd1, C_EMRS = 4'd2, C_REF = 4'd3,
        C_SREF = 4'd4, C_ACT = 4'd5, C_RD = 4'd6, C_RDA = 4'd7,
        C_WR = 4'd8, C_WRA = 4'd9, C_BST = 4'd10, C_PRE = 4'd11,
        C_PREA = 4'd12, C_PDN = 4'd13, C_DPD = 4'd14, C_EXIT = 4'd15
    } cmd_e;

    typedef enum logic [1:0] {B_IDLE = 2'd0, B_ACTIVE = 2'd1, B_BURST = 2'd2} bank_e;

    typedef enum logic [2:0] {
        D_NORMAL = 3'd0, D_PWRDN = 3'd1, D_SELFREF = 3'd2, D_DEEP = 3'd3, D_UNINIT = 3'd4
    } dev_e;

    typedef enum logic [2:0] {
        V_NONE = 3'd0, V_OPEN = 3'd1, V_GAP = 3'd2, V_UNINIT = 3'd3,
        V_IDLE = 3'd4, V_BUSY = 3'd5, V_REACT = 3'd6
    } viol_e;

    // True for the four column commands.
    function automatic logic is_col(cmd_e c);
        return (c == C_RD) || (c == C_RDA) || (c == C_WR) || (c == C_WRA);
    endfunction
endpackage

// File: rtl/sdcmd_decode.sv
// Pin-level command decoder. Purely combinational.
// Assumes cke_prev is the clock-enable level seen on the previous edge.
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int BA_W = 1
) (
    input  logic            cke_prev,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output cmd_e            cmd
);
    // Map the pin levels to one command.
    always_comb begin
        cmd = C_NOP;
        if (!cke_prev) begin
            cmd = cke ? C_EXIT : C_NOP;
        end else if (cs_n) begin
            cmd = cke ? C_NOP : C_PDN;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = (ba == '0) ? C_MRS : C_EMRS;
                3'b001: cmd = cke ? C_REF : C_SREF;
                3'b011: cmd = C_ACT;
                3'b101: cmd = a10 ? C_RDA : C_RD;
                3'b100: cmd = a10 ? C_WRA : C_WR;
                3'b110: cmd = cke ? C_BST : C_DPD;
                3'b010: cmd = a10 ? C_PREA : C_PRE;
                default: cmd = cke ? C_NOP : C_PDN;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_bank.sv
// One bank's state tracker: idle, active, or bursting with auto precharge.
// Reports the bank-local legality error for the current command.
// Assumes bl holds a value of 1, 2, 4 or 8.
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int BL_W = 4,
    parameter int CNT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic            hit,
    input  logic [BL_W-1:0] bl,
    output bank_e           state_o,
    output viol_e           err_o
);
    bank_e             state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BL_W-1:0]   bl_m2;

    assign bl_m2   = bl - BL_W'(2);
    assign state_o = state_q;

    // Legality of the current command against this bank.
    always_comb begin
        err_o = V_NONE;
        if (hit && (is_col(cmd) || cmd == C_PRE)) begin
            if (state_q == B_IDLE)       err_o = V_IDLE;
            else if (state_q == B_BURST) err_o = V_BUSY;
        end else if (hit && cmd == C_ACT && state_q != B_IDLE) begin
            err_o = V_REACT;
        end
    end

    // Bank state and auto-precharge burst countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                B_IDLE: if (hit && cmd == C_ACT) state_q <= B_ACTIVE;
                B_ACTIVE: begin
                    if (hit && (cmd == C_RDA || cmd == C_WRA)) begin
                        if (bl == BL_W'(1)) state_q <= B_IDLE;
                        else begin
                            state_q <= B_BURST;
                            cnt_q   <= bl_m2[CNT_W-1:0];
                        end
                    end else if ((hit && cmd == C_PRE) || cmd == C_PREA) begin
                        state_q <= B_IDLE;
                    end
                end
                B_BURST: begin
                    if (cnt_q == '0) state_q <= B_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= B_IDLE;
            endcase
        end
    end

    // R3
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_IDLE && hit && cmd == C_ACT) |=> (state_q == B_ACTIVE));
    // R5
    ap_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_ACTIVE && hit && cmd == C_RDA && bl == BL_W'(1)) |=> (state_q == B_IDLE));
    // R5
    busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_BURST && hit && is_col(cmd)) |-> (err_o == V_BUSY));
endmodule

// File: rtl/sdram_cmd_monitor.sv
// Top of the SDRAM command monitor: decodes pins, tracks banks and device
// power state, applies the sequencing rules and holds the first violation.
// Assumes the device starts initialised after reset.
module sdram_cmd_monitor
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   viol_clr,
    input  logic                   cke_prev,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic                   a10,
    input  logic [2:0]             addr_lo,
    output logic [3:0]             cmd_o,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic [2:0]             dev_state_o,
    output logic                   viol_o,
    output logic [2:0]             viol_code_o
);
    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int CNT_W = BL_W - 1;

    cmd_e            cmd;
    dev_e            dev_q;
    viol_e           code_q, code_now, bank_err;
    viol_e           berr [NUM_BANKS];
    bank_e           bst  [NUM_BANKS];
    logic [BL_W-1:0] bl_q;
    logic [1:0]      gap_q;
    logic            quiet, any_open;

    sdcmd_decode #(.BA_W(BA_W)) dec_i (
        .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd(cmd));

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        sdcmd_bank #(.BL_W(BL_W), .CNT_W(CNT_W)) bank_i (
            .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(ba == BA_W'(i)),
            .bl(bl_q), .state_o(bst[i]), .err_o(berr[i]));
        assign bank_state_o[2*i +: 2] = bst[i];
    end

    assign quiet       = (cmd == C_NOP) || (cmd == C_PDN) || (cmd == C_EXIT);
    assign cmd_o       = cmd;
    assign dev_state_o = dev_q;
    assign viol_code_o = code_q;
    assign viol_o      = (code_q != V_NONE);

    // Lowest-numbered bank error and any-bank-open summary.
    always_comb begin
        bank_err = V_NONE;
        any_open = 1'b0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (berr[i] != V_NONE) bank_err = berr[i];
            if (bst[i] != B_IDLE)  any_open = 1'b1;
        end
    end

    // Device-level rules take priority over bank-level errors.
    always_comb begin
        if (dev_q == D_UNINIT && !quiet && cmd != C_MRS)
            code_now = V_UNINIT;
        else if (gap_q != 2'd0 && !quiet)
            code_now = V_GAP;
        else if (any_open && (cmd == C_MRS || cmd == C_EMRS || cmd == C_REF || cmd == C_SREF))
            code_now = V_OPEN;
        else
            code_now = bank_err;
    end

    // Sticky first-violation register with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || viol_clr)         code_q <= V_NONE;
        else if (code_q == V_NONE)      code_q <= code_now;
    end

    // Burst length and post-mode-write quiet window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_q  <= BL_W'(1);
            gap_q <= 2'd0;
        end else begin
            if (cmd == C_MRS && addr_lo < 3'd4) bl_q <= BL_W'(1) << addr_lo[1:0];
            if (cmd == C_MRS || cmd == C_EMRS)  gap_q <= 2'd2;
            else if (gap_q != 2'd0)             gap_q <= gap_q - 2'd1;
        end
    end

    // Device power-state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_q <= D_NORMAL;
        else begin
            unique case (dev_q)
                D_NORMAL: begin
                    if (cmd == C_SREF)     dev_q <= D_SELFREF;
                    else if (cmd == C_PDN) dev_q <= D_PWRDN;
                    else if (cmd == C_DPD) dev_q <= D_DEEP;
                end
                D_PWRDN, D_SELFREF: if (cmd == C_EXIT) dev_q <= D_NORMAL;
                D_DEEP:   if (cmd == C_EXIT) dev_q <= D_UNINIT;
                D_UNINIT: if (cmd == C_MRS)  dev_q <= D_NORMAL;
                default:  dev_q <= D_NORMAL;
            endcase
        end
    end

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != V_NONE && !viol_clr) |=> $stable(code_q));
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_clr |=> (code_q == V_NONE));
    // R7
    gap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q != 2'd0 && !quiet && !viol_clr) |=> (code_q != V_NONE));
    // R8
    deep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_q == D_DEEP && cmd == C_EXIT) |=> (dev_q == D_UNINIT));
endmodule

// File: tb/sdram_cmd_monitor_tb_top.sv
// Directed bench: one task per scenario, each checks its own results.
module sdram_cmd_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic viol_clr = 1'b0;
    logic cke_prev = 1'b1, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic ba = 1'b0, a10 = 1'b0;
    logic [2:0] addr_lo = 3'd0;
    logic [3:0] cmd_o;
    logic [3:0] bank_state_o;
    logic [2:0] dev_state_o;
    logic       viol_o;
    logic [2:0] viol_code_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sdram_cmd_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .cke_prev(cke_prev),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .addr_lo(addr_lo), .cmd_o(cmd_o),
        .bank_state_o(bank_state_o), .dev_state_o(dev_state_o),
        .viol_o(viol_o), .viol_code_o(viol_code_o));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic cp, ck, cs, r, c, w, b, a, input logic [2:0] lo);
        cke_prev = cp; cke = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ba = b; a10 = a; addr_lo = lo;
    endtask

    // Apply pins on a falling edge, let one rising edge sample them.
    task automatic drive(input logic cp, ck, cs, r, c, w, b, a, input logic [2:0] lo);
        @(negedge clk);
        set_pins(cp, ck, cs, r, c, w, b, a, lo);
        @(posedge clk);
        #2;
    endtask

    task automatic nop();            drive(1,1,1,1,1,1,0,0,3'd0); endtask
    task automatic act(input logic b); drive(1,1,0,0,1,1,b,0,3'd0); endtask
    task automatic rd(input logic b, input logic ap); drive(1,1,0,1,0,1,b,ap,3'd0); endtask
    task automatic pre(input logic b); drive(1,1,0,0,1,0,b,0,3'd0); endtask
    task automatic preall();         drive(1,1,0,0,1,0,0,1,3'd0); endtask
    task automatic mrs(input logic [2:0] lo); drive(1,1,0,0,0,0,0,0,lo); endtask
    task automatic refresh();        drive(1,1,0,0,0,1,0,0,3'd0); endtask
    task automatic clear();
        @(negedge clk);
        set_pins(1,1,1,1,1,1,0,0,3'd0);
        viol_clr = 1'b1;
        @(posedge clk);
        #2;
        viol_clr = 1'b0;
    endtask

    // Decode check while reset holds the state.
    task automatic dec(input logic cp, ck, cs, r, c, w, b, a, input int exp, input string req);
        @(negedge clk);
        set_pins(cp, ck, cs, r, c, w, b, a, 3'd0);
        #1;
        check(req, cmd_o, exp);
    endtask

    task automatic t_decode();
        dec(1,1,1,0,0,0,0,0, 0, "R1 deselect");
        dec(1,1,0,1,1,1,0,0, 0, "R1 nop");
        dec(1,1,0,0,0,0,0,0, 1, "R1 mrs");
        dec(1,1,0,0,0,0,1,0, 2, "R1 emrs");
        dec(1,1,0,0,0,1,0,0, 3, "R1 refresh");
        dec(1,1,0,0,1,1,1,0, 5, "R1 activate");
        dec(1,1,0,1,0,1,0,0, 6, "R1 read");
        dec(1,1,0,1,0,1,0,1, 7, "R1 read ap");
        dec(1,1,0,1,0,0,0,0, 8, "R1 write");
        dec(1,1,0,1,0,0,0,1, 9, "R1 write ap");
        dec(1,1,0,1,1,0,0,0, 10, "R1 burst stop");
        dec(1,1,0,0,1,0,0,0, 11, "R1 precharge");
        dec(1,1,0,0,1,0,0,1, 12, "R1 precharge all");
        dec(1,0,0,0,0,1,0,0, 4, "R2 self refresh entry");
        dec(1,0,0,1,1,0,0,0, 14, "R2 deep entry");
        dec(1,0,1,0,0,0,0,0, 13, "R2 power down entry");
        dec(0,1,0,0,1,1,0,0, 15, "R2 exit");
        dec(0,0,0,0,1,1,0,0, 0, "R2 held low");
        @(posedge clk); #2;
        check("R12 reset code", viol_code_o, 0);
        check("R12 reset banks", bank_state_o, 0);
        check("R12 reset dev", dev_state_o, 0);
    endtask

    task automatic t_bl_reset();
        act(0); rd(0, 1);
        check("R11 reset BL1 bank idle", bank_state_o, 0);
        check("R11 reset BL1 no error", viol_code_o, 0);
    endtask

    task automatic t_bank();
        act(0);
        check("R3 activate", bank_state_o, 1);
        rd(0, 0);
        check("R3 read keeps active", bank_state_o, 1);
        pre(0);
        check("R3 precharge idle", bank_state_o, 0);
        act(0); act(1);
        check("R3 both active", bank_state_o, 5);
        preall();
        check("R3 precharge all", bank_state_o, 0);
        check("R3 clean so far", viol_code_o, 0);
        act(1); act(1);
        check("R3 reactivate code", viol_code_o, 6);
        check("R10 flag", viol_o, 1);
        clear();
        check("R10 cleared", viol_code_o, 0);
        preall();
    endtask

    task automatic t_idle_sticky();
        rd(1, 0);
        check("R4 read idle", viol_code_o, 4);
        act(0); act(0);
        check("R10 first kept", viol_code_o, 4);
        clear(); preall();
        pre(0);
        check("R4 precharge idle", viol_code_o, 4);
        clear();
    endtask

    task automatic t_burst();
        mrs(3'd2); nop(); nop();
        check("R7 quiet ok", viol_code_o, 0);
        act(0); act(1); rd(0, 1);
        rd(1, 0);
        check("R5 other bank usable", viol_code_o, 0);
        check("R5 bursting e1", bank_state_o[1:0], 2);
        nop();
        check("R5 bursting e2", bank_state_o[1:0], 2);
        nop();
        check("R5 idle at BL", bank_state_o[1:0], 0);
        rd(0, 0);
        check("R5 closed by ap", viol_code_o, 4);
        clear(); preall();
        act(0); rd(0, 1); rd(0, 0);
        check("R5 busy code", viol_code_o, 5);
        clear(); nop(); nop(); nop(); preall();
        mrs(3'd5); nop(); nop();
        act(0); rd(0, 1); nop(); nop();
        check("R11 code 5 keeps BL4", bank_state_o[1:0], 2);
        nop();
        check("R11 BL4 end", bank_state_o[1:0], 0);
    endtask

    task automatic t_rules();
        mrs(3'd0); act(0);
        check("R7 gap", viol_code_o, 2);
        clear(); preall(); nop(); nop();
        act(0); refresh();
        check("R6 refresh open", viol_code_o, 1);
        clear(); preall();
    endtask

    task automatic t_power();
        drive(1,0,1,1,1,1,0,0,3'd0);
        check("R8 power down", dev_state_o, 1);
        drive(0,1,1,1,1,1,0,0,3'd0);
        check("R8 power down exit", dev_state_o, 0);
        drive(1,0,0,0,0,1,0,0,3'd0);
        check("R8 self refresh", dev_state_o, 2);
        drive(0,0,1,1,1,1,0,0,3'd0);
        drive(0,1,1,1,1,1,0,0,3'd0);
        check("R8 self refresh exit", dev_state_o, 0);
        drive(1,0,0,1,1,0,0,0,3'd0);
        check("R8 deep", dev_state_o, 3);
        drive(0,0,1,1,1,1,0,0,3'd0);
        drive(0,1,1,1,1,1,0,0,3'd0);
        check("R8 deep exit", dev_state_o, 4);
        check("R8 no error yet", viol_code_o, 0);
        act(0);
        check("R9 uninit code", viol_code_o, 3);
        clear(); preall();
        mrs(3'd0);
        check("R9 reinit", dev_state_o, 0);
        nop(); nop();
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_decode();
        @(negedge clk);
        set_pins(1,1,1,1,1,1,0,0,3'd0);
        rst_n = 1'b1;
        t_bl_reset();
        t_bank();
        t_idle_sticky();
        t_burst();
        t_rules();
        t_power();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule